// File: doc/BRIEF.md
# Free-Running Timer with Masked Compare-Clear Interrupt

The block is a 16-bit up counter that runs without stopping unless told to. It counts either a power-of-two division of the system clock or the rising edges of an external count input, which is first passed through a two-stage synchroniser. When clear-on-match is enabled, a count tick that finds the counter equal to the compare value returns the counter to zero and produces a compare event. A tick that wraps the counter from all ones to zero produces an overflow event. Each event kind has a sticky flag and an enable, and an interrupt output is driven while both are set.

A 3-bit reload counter stands between compare events and the compare flag. Software programs a skip count N. N events in a row are swallowed, and the event after them sets the flag. The mask counter is reloaded with N every time the control word is written. Software works through a single 16-bit control/status word. Flags are cleared by writing 0 and are left alone by writing 1. A read issued as part of a read-modify-write returns both flags as 1, so the write that follows the read never clears a flag by accident.

Top module: `frc_timer`

## Requirements
- R1: While reset is active and right after it, every control bit, both flags and the counter read 0, and both interrupt outputs are low. Bits 14 and 13 of the control word always read 0.
- R2: With bit 15 = 0 and division code k in bits 2..0 (k = 0..7), the counter advances by exactly one every 2^k system clock cycles. Over any 256 consecutive cycles it advances by 256 >> k.
- R3: With bit 15 = 1, the counter advances once for each rising edge of `ext_cnt_i`, counted after two synchronising flip-flops. The source change takes effect on the clock that writes the control word.
- R4: While the halt bit (bit 5) is 1, the counter keeps its value.
- R5: Writing 1 to bit 3 requests a clear. The counter becomes 0 on the next count tick of the selected source, and this happens even while halted. Bit 3 reads 1 while the request is pending and 0 once it has been served. Writing 0 to bit 3 has no effect.
- R6: With bit 4 = 1, a counting tick that finds the counter equal to `cmp_val_i` loads 0 instead of incrementing, and it raises a compare event. With bit 4 = 0, the compare value is ignored and the counter counts through the full range.
- R7: A counting tick that takes the counter from FFFF to 0000 sets the overflow flag (bit 7).
- R8: Bits 12..10 hold a skip count N. After any control write, the first N compare events leave the compare flag (bit 9) unchanged and the next one sets it. N = 0 lets every event through, and the skip count reloads after each event that gets through.
- R9: Writing 0 to bit 9 or bit 7 clears that flag, and writing 1 leaves it unchanged. A flag set event in the same cycle as a clear write wins.
- R10: While `rmw_i` is 1, bits 9 and 7 of `rdata_o` read 1 whatever the flag values. All other bits are unaffected.
- R11: `cmp_irq_o` is high while the compare flag and bit 8 are both 1. `ovf_irq_o` is high while the overflow flag and bit 6 are both 1.
- R12: Every writable bit reads back at its own position: source 15, skip count 12..10, compare enable 8, overflow enable 6, halt 5, clear-on-match 4, division 2..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_cnt_i | input | 1 | External count input, asynchronous |
| wr_en_i | input | 1 | Control word write strobe |
| wdata_i | input | 16 | Control word write data |
| rmw_i | input | 1 | The current read belongs to a read-modify-write |
| cmp_val_i | input | 16 | Compare-clear value |
| rdata_o | output | 16 | Control/status word read data |
| cnt_o | output | 16 | Counter value |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| cmp_irq_o | output | 1 | Compare-clear interrupt request |

## Verification
The bench finds the first cycle in which the compare flag appears for skip counts of 2 and 0, expecting the 15th and 5th tick with a compare value of 4. An off-by-one mask counter moves that cycle by a whole compare period, and a mask that never reloads on write fires too early. Each of the eight division codes is measured over a 256-cycle window, so a prescaler decoded one bit off gives a count that is twice or half the expected value. The bench also checks the exact wrap cycle at 65536 ticks, that a write of 1 to a flag leaves it alone, that read-modify-write reads return 1, and that halt freezes external counting. A design that cleared flags on a write of 1, or ignored the halt while in external mode, would show a wrong flag or a wrong count.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned DIV_W   = 3;
  localparam int unsigned MSK_W   = 3;
  localparam int unsigned SYNC_N  = 2;

  // control word bit positions (software decodes these)
  localparam int unsigned B_EXT   = 15;
  localparam int unsigned B_MSK   = 10;
  localparam int unsigned B_CFLG  = 9;
  localparam int unsigned B_CIE   = 8;
  localparam int unsigned B_OFLG  = 7;
  localparam int unsigned B_OIE   = 6;
  localparam int unsigned B_HALT  = 5;
  localparam int unsigned B_MODE  = 4;
  localparam int unsigned B_SCLR  = 3;
  localparam int unsigned B_DIV   = 0;
endpackage

// File: rtl/frc_tick_gen.sv
module frc_tick_gen #(
  parameter int unsigned DIV_W  = frc_pkg::DIV_W,
  parameter int unsigned SYNC_N = frc_pkg::SYNC_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  div_mask;
  logic [SYNC_N:0]   sync_q;   // SYNC_N sync stages plus one edge stage
  logic              int_tick, ext_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      sync_q <= '0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      sync_q <= {sync_q[SYNC_N-1:0], ext_i};
    end
  end

  for (genvar b = 0; b < PRE_W; b++) begin : g_mask
    assign div_mask[b] = (div_i > DIV_W'(b));
  end

  assign int_tick = &(pre_q | ~div_mask);
  assign ext_tick = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
  assign tick_o   = ext_sel_i ? ext_tick : int_tick;
endmodule

// File: rtl/frc_mask_ctr.sv
module frc_mask_ctr #(
  parameter int unsigned MSK_W = frc_pkg::MSK_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MSK_W-1:0] load_val_i,
  input  logic [MSK_W-1:0] reload_val_i,
  input  logic             evt_i,
  output logic             pass_o,
  output logic [MSK_W-1:0] cnt_o
);
  logic [MSK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (evt_i && cnt_q == '0) cnt_q <= reload_val_i;
    else if (evt_i)             cnt_q <= cnt_q - 1'b1;
  end

  assign pass_o = evt_i && (cnt_q == '0);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int unsigned CNT_W = frc_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             clr_req_i,
  input  logic             cmp_en_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cmp_evt_o,
  output logic             ovf_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run;

  assign run       = tick_i && !halt_i && !clr_req_i;
  assign cmp_evt_o = run && cmp_en_i && (cnt_q == cmp_val_i);
  assign ovf_evt_o = run && !cmp_evt_o && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (tick_i && clr_req_i)     cnt_q <= '0;  // pending clear served even when halted
    else if (cmp_evt_o)               cnt_q <= '0;
    else if (run)                     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/frc_timer.sv
module frc_timer
  import frc_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_cnt_i,
  input  logic          wr_en_i,
  input  logic [15:0]   wdata_i,
  input  logic          rmw_i,
  input  logic [CW-1:0] cmp_val_i,
  output logic [15:0]   rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_irq_o,
  output logic          cmp_irq_o
);
  logic             ext_sel_q, cmp_ie_q, ovf_ie_q, halt_q, mode_q, sclr_q;
  logic             cmp_flag_q, ovf_flag_q;
  logic [MSK_W-1:0] msk_q;
  logic [DIV_W-1:0] div_q;
  logic             tick, cmp_evt, ovf_evt, cmp_set;
  logic [MSK_W-1:0] msk_cnt;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[B_EXT-1:B_MSK+MSK_W];

  frc_tick_gen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_tick (
    .clk_i, .rst_ni, .ext_sel_i(ext_sel_q), .div_i(div_q),
    .ext_i(ext_cnt_i), .tick_o(tick)
  );

  frc_counter #(.CNT_W(CW)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .halt_i(halt_q), .clr_req_i(sclr_q),
    .cmp_en_i(mode_q), .cmp_val_i, .cnt_o, .cmp_evt_o(cmp_evt), .ovf_evt_o(ovf_evt)
  );

  frc_mask_ctr #(.MSK_W(MSK_W)) u_msk (
    .clk_i, .rst_ni, .load_i(wr_en_i), .load_val_i(wdata_i[B_MSK +: MSK_W]),
    .reload_val_i(msk_q), .evt_i(cmp_evt), .pass_o(cmp_set), .cnt_o(msk_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_sel_q <= 1'b0; msk_q <= '0; cmp_ie_q <= 1'b0; ovf_ie_q <= 1'b0;
      halt_q <= 1'b0; mode_q <= 1'b0; div_q <= '0;
    end else if (wr_en_i) begin
      ext_sel_q <= wdata_i[B_EXT];
      msk_q     <= wdata_i[B_MSK +: MSK_W];
      cmp_ie_q  <= wdata_i[B_CIE];
      ovf_ie_q  <= wdata_i[B_OIE];
      halt_q    <= wdata_i[B_HALT];
      mode_q    <= wdata_i[B_MODE];
      div_q     <= wdata_i[B_DIV +: DIV_W];
    end
  end

  // flags: write 0 clears, write 1 ignored, set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_flag_q <= 1'b0;
      ovf_flag_q <= 1'b0;
      sclr_q     <= 1'b0;
    end else begin
      cmp_flag_q <= cmp_set | (cmp_flag_q & ~(wr_en_i & ~wdata_i[B_CFLG]));
      ovf_flag_q <= ovf_evt | (ovf_flag_q & ~(wr_en_i & ~wdata_i[B_OFLG]));
      sclr_q     <= (wr_en_i & wdata_i[B_SCLR]) | (sclr_q & ~tick);
    end
  end

  assign rdata_o = {ext_sel_q, 2'b00, msk_q, cmp_flag_q | rmw_i, cmp_ie_q,
                    ovf_flag_q | rmw_i, ovf_ie_q, halt_q, mode_q, sclr_q, div_q};

  assign cmp_irq_o = cmp_flag_q & cmp_ie_q;
  assign ovf_irq_o = ovf_flag_q & ovf_ie_q;
endmodule

// File: rtl/frc_timer_chk.sv
module frc_timer_chk #(
  parameter int unsigned CW    = frc_pkg::CNT_W,
  parameter int unsigned MSK_W = frc_pkg::MSK_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             wr_cflg_i,
  input logic             wr_sclr_i,
  input logic             rmw_i,
  input logic             rd_cflg_i,
  input logic             rd_oflg_i,
  input logic [1:0]       rd_rsvd_i,
  input logic [CW-1:0]    cnt_i,
  input logic             halt_i,
  input logic             sclr_i,
  input logic             tick_i,
  input logic             cmp_flag_i,
  input logic             ovf_flag_i,
  input logic             cmp_set_i,
  input logic [MSK_W-1:0] msk_i,
  input logic [MSK_W-1:0] msk_cnt_i
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_rsvd_i == 2'b00); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1 || cnt_i == '0)); // R2
  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !sclr_i) |=> $stable(cnt_i)); // R4
  AST_SCLR_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclr_i && tick_i && !(wr_en_i && wr_sclr_i)) |=> (cnt_i == '0 && !sclr_i)); // R5
  AST_CMP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_set_i |=> (cnt_i == '0)); // R6
  AST_OVF_FROM_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_i) |-> ($past(cnt_i) == '1 && cnt_i == '0)); // R7
  AST_MASK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msk_cnt_i <= msk_i); // R8
  AST_FLAG_W0_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_cflg_i && !cmp_set_i) |=> !cmp_flag_i); // R9
  AST_RMW_FLAGS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmw_i |-> (rd_cflg_i && rd_oflg_i)); // R10
endmodule

bind frc_timer frc_timer_chk #(.CW(CW), .MSK_W(frc_pkg::MSK_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
  .wr_cflg_i(wdata_i[9]), .wr_sclr_i(wdata_i[3]), .rmw_i(rmw_i),
  .rd_cflg_i(rdata_o[9]), .rd_oflg_i(rdata_o[7]), .rd_rsvd_i(rdata_o[14:13]),
  .cnt_i(cnt_o), .halt_i(halt_q), .sclr_i(sclr_q), .tick_i(tick),
  .cmp_flag_i(cmp_flag_q), .ovf_flag_i(ovf_flag_q), .cmp_set_i(cmp_set),
  .msk_i(msk_q), .msk_cnt_i(msk_cnt)
);

// File: tb/frc_timer_test.sv
module frc_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_cnt_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic        rmw_i = 1'b0;
  logic [15:0] cmp_val_i = '0;
  logic [15:0] rdata_o, cnt_o;
  logic        ovf_irq_o, cmp_irq_o;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  // {division code, expected advance over 256 cycles}
  localparam logic [19:0] DIV_VEC [8] = '{
    {3'd0, 17'd256}, {3'd1, 17'd128}, {3'd2, 17'd64}, {3'd3, 17'd32},
    {3'd4, 17'd16},  {3'd5, 17'd8},   {3'd6, 17'd4},  {3'd7, 17'd2}
  };

  frc_timer uut (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not complete, actual cycles=%0d expected below 190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ext, skip, cmp ie, ovf ie, halt, mode, sclr, div, flag bits written
  function automatic logic [15:0] ctl(bit ext, bit [2:0] msk, bit cie, bit oie, bit halt,
                                      bit mode, bit sclr, bit [2:0] div, bit keep);
    return {ext, 2'b00, msk, keep, cie, keep, oie, halt, mode, sclr, div};
  endfunction

  // called at a negedge; write lands on the following posedge
  task automatic wr(logic [15:0] v);
    wr_en_i = 1'b1;
    wdata_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic clear_cnt();
    wr(ctl(0, 0, 0, 0, 1, 0, 1, 0, 1));
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    int first;
    logic irq_at_first;
    logic [15:0] hold;

    repeat (3) @(negedge clk_i);
    check("R1 reset rdata", rdata_o, 16'h0000);
    check("R1 reset count", cnt_o, 16'h0000);
    check("R1 reset irqs", {ovf_irq_o, cmp_irq_o}, 2'b00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // prescaler table
    for (int i = 0; i < 8; i++) begin
      clear_cnt();
      check("R5 clear served", cnt_o, 16'h0000);
      check("R5 sclr reads 0", rdata_o[3], 1'b0);
      wr(ctl(0, 0, 0, 0, 0, 0, 0, DIV_VEC[i][19:17], 1));
      repeat (255) @(negedge clk_i);
      wr(ctl(0, 0, 0, 0, 1, 0, 0, DIV_VEC[i][19:17], 1));
      check($sformatf("R2 div code %0d", i), cnt_o, 32'(DIV_VEC[i][16:0]));
      if (i == 3) begin
        hold = cnt_o;
        repeat (20) @(negedge clk_i);
        check("R4 halt holds count", cnt_o, hold);
      end
    end

    // sclr pending while halted with slow clock; write 0 to bit 3 does not cancel
    wr(ctl(0, 0, 0, 0, 1, 0, 1, 7, 1));
    wr(ctl(0, 0, 0, 0, 1, 0, 0, 7, 1));
    check("R5 sclr pending reads 1", rdata_o[3], 1'b1);
    repeat (130) @(negedge clk_i);
    check("R5 slow clear served", {rdata_o[3], cnt_o}, 17'h0);

    // compare clear with skip count 2
    cmp_val_i = 16'd4;
    wr(ctl(0, 0, 0, 0, 1, 0, 1, 0, 0));
    repeat (2) @(negedge clk_i);
    wr(ctl(0, 3'd2, 1, 0, 0, 1, 0, 0, 1));
    check("R12 skip count readback", rdata_o[12:10], 3'd2);
    first = 0; irq_at_first = 1'b0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk_i);
      if (i == 4) check("R6 counts up to compare", cnt_o, 16'd4);
      if (i == 5) check("R6 match loads zero", cnt_o, 16'd0);
      if (rdata_o[9] && first == 0) begin first = i; irq_at_first = cmp_irq_o; end
    end
    check("R8 skip 2 flags on third event", first, 15);
    check("R11 compare irq with flag", irq_at_first, 1'b1);
    wr(ctl(0, 0, 1, 0, 1, 1, 0, 0, 1));
    check("R9 write 1 keeps flag", rdata_o[9], 1'b1);
    wr(ctl(0, 0, 1, 0, 1, 1, 0, 0, 0));
    check("R9 write 0 clears flag", rdata_o[9], 1'b0);
    check("R11 irq drops with flag", cmp_irq_o, 1'b0);
    wr(ctl(0, 0, 1, 0, 1, 1, 0, 0, 1));
    check("R9 write 1 does not set flag", rdata_o[9], 1'b0);
    rmw_i = 1'b1;
    #1 check("R10 rmw reads flags 1", {rdata_o[9], rdata_o[7]}, 2'b11);
    rmw_i = 1'b0;
    #1 check("R10 plain read flags 0", {rdata_o[9], rdata_o[7]}, 2'b00);
    @(negedge clk_i);

    // skip count 0
    clear_cnt();
    wr(ctl(0, 3'd0, 0, 0, 0, 1, 0, 0, 0));
    first = 0; irq_at_first = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk_i);
      if (rdata_o[9] && first == 0) begin first = i; irq_at_first = cmp_irq_o; end
    end
    check("R8 skip 0 flags first event", first, 5);
    check("R11 irq stays low when disabled", irq_at_first, 1'b0);

    // mode 0 ignores compare
    wr(ctl(0, 0, 0, 0, 1, 0, 1, 0, 0));
    repeat (2) @(negedge clk_i);
    wr(ctl(0, 0, 0, 0, 0, 0, 0, 0, 1));
    repeat (9) @(negedge clk_i);
    wr(ctl(0, 0, 0, 0, 1, 0, 0, 0, 1));
    check("R6 mode 0 passes compare", {rdata_o[9], cnt_o}, {1'b0, 16'd10});

    // full readback
    wr(16'hFFFF);
    check("R12 readback all ones", rdata_o, 16'h9D7F);
    clear_cnt();

    // external source
    wr(ctl(1, 0, 0, 0, 0, 0, 0, 0, 1));
    for (int p = 0; p < 10; p++) begin
      ext_cnt_i = 1'b1; repeat (3) @(negedge clk_i);
      ext_cnt_i = 1'b0; repeat (3) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
    check("R3 external edges counted", cnt_o, 16'd10);
    wr(ctl(1, 0, 0, 0, 1, 0, 0, 0, 1));
    for (int p = 0; p < 5; p++) begin
      ext_cnt_i = 1'b1; repeat (3) @(negedge clk_i);
      ext_cnt_i = 1'b0; repeat (3) @(negedge clk_i);
    end
    check("R4 halt stops external count", cnt_o, 16'd10);

    // overflow
    clear_cnt();
    wr(ctl(0, 0, 0, 1, 0, 0, 0, 0, 1));
    first = 0; irq_at_first = 1'b0;
    for (int i = 1; i <= 65600 && first == 0; i++) begin
      @(negedge clk_i);
      if (rdata_o[7]) begin first = i; irq_at_first = ovf_irq_o; end
    end
    check("R7 wrap sets overflow flag", first, 65536);
    check("R11 overflow irq", irq_at_first, 1'b1);
    wr(ctl(0, 0, 0, 1, 0, 0, 0, 0, 0));
    check("R9 overflow flag write 0 clears", {rdata_o[7], ovf_irq_o}, 2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule